// File: doc/BRIEF.md
# Sliding Window Jet Finder

This block searches one frame of calorimeter tower energies for jet candidates. Each tower value arrives already combined (electromagnetic plus hadronic) at a granularity of 0.1 × 0.1 in eta × phi. A frame is a core region surrounded by an environment border of towers, all presented in parallel on a single input bus for one bunch tick. For every core tower the block adds up a square window of towers centred on it, stepping one tower at a time in both directions. It evaluates all window positions in the same cycle.

A core position is reported as a candidate only when its window sum is a local maximum among the eight neighbouring windows. The neighbouring windows may lie outside the core and reach into the environment. This means an object centred on a neighbouring core region suppresses the edge windows here, and a jet is not counted twice. Ties on a plateau of equal sums are resolved by raster order, so exactly one window of a plateau survives. The outputs are one flag and one 16-bit energy per core position, two register stages after the frame is taken.

With the default parameters the core is 12 × 8 towers, the environment is 4 towers on each side (frame 20 × 16), and the window is 9 × 9 (a radius of about 0.45). Smaller grids and windows can be selected through parameters. The environment must be at least half the window width, and the window width must be odd.

Top module: `sliding_jet_finder`

## Requirements
- R1: While reset is held and after it is released, out_valid and every bit of cand_flag are 0 until a frame has gone through the pipeline.
- R2: A frame captured on a clock edge with in_valid high appears on the outputs after the next clock edge, with out_valid high for exactly one cycle per frame. Frames on consecutive cycles come out on consecutive cycles, in the order they went in.
- R3: Core position (ce, cp) has output index i = cp*CORE_ETA + ce. It corresponds to frame tower (ce+ENV, cp+ENV). Tower (fe, fp) occupies towers_i bits [(fp*FRAME_ETA+fe)*TOWER_W +: TOWER_W]. cand_sum[i*16 +: 16] is the sum of the WIN × WIN towers centred on that tower.
- R4: cand_flag[i] is 1 only if the window sum of i meets two conditions. It must be strictly greater than the sums of the neighbouring windows earlier in raster order: the three at phi-1, and the one at the same phi and eta-1. It must also be greater than or equal to the four later neighbours. As a result, two adjacent core positions are never both flagged.
- R5: Neighbour windows centred outside the core are evaluated from the environment towers, with towers beyond the frame counted as zero. Energy in the environment can therefore suppress a core candidate.
- R6: A window whose sum is zero is never flagged.
- R7: A sum above 65535 is reported as 65535. The local-maximum comparisons use the full-precision sums.
- R8: While out_valid is low, cand_flag is all zero and cand_sum holds its last value. Towers driven while in_valid is low do not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the cycle in which towers_i carries a frame |
| towers_i | input | FRAME_ETA*FRAME_PHI*TOWER_W | Full tower frame, eta-fastest |
| out_valid | output | 1 | Outputs carry a frame result |
| cand_flag | output | CORE_ETA*CORE_PHI | Candidate flag per core position |
| cand_sum | output | CORE_ETA*CORE_PHI*16 | Saturated window sum per core position |

## Verification
The finder is driven with the following frames:
- An empty frame, which separates the zero-sum rule from the peak test.
- Isolated towers, which give a plateau of equal windows and so test the raster tie rule.
- Twin equal towers, and a uniform field in which every core window is equal, so that only the first raster position may survive.
- Frames that place large deposits in the environment next to the core edges and in a frame corner, which show whether the clipped neighbour windows take part in the test.
- A frame with every tower at full scale, which exercises saturation.
- Back-to-back frames and idle-cycle tower changes, which separate correct pipelining from outputs that leak the live input.

// File: rtl/jf_pkg.sv
package jf_pkg;

    localparam int OUT_W = 16;

    // Clamp a full-precision sum to the reported width.
    function automatic logic [OUT_W-1:0] sat_to_out(input logic [31:0] v);
        if ((v >> OUT_W) != 32'd0) begin
            return '1;
        end
        return v[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/jf_window_sums.sv
module jf_window_sums #(
    parameter int FRAME_ETA = 20,
    parameter int FRAME_PHI = 16,
    parameter int CORE_ETA  = 12,
    parameter int CORE_PHI  = 8,
    parameter int ENV       = 4,
    parameter int HALF      = 4,
    parameter int TOWER_W   = 10,
    parameter int SUM_W     = 17
) (
    input  logic [FRAME_ETA*FRAME_PHI*TOWER_W-1:0]     towers_i,
    output logic [(CORE_ETA+2)*(CORE_PHI+2)*SUM_W-1:0] sums_o
);
    // Extended grid: core plus one ring, so every core position has its
    // eight neighbour windows available.
    localparam int XE = CORE_ETA + 2;
    localparam int XP = CORE_PHI + 2;

    // Eta strips: for each extended eta centre and each frame phi row.
    logic [XE*FRAME_PHI*SUM_W-1:0] strip_flat;

    for (genvar xe = 0; xe < XE; xe++) begin : g_strip_e
        for (genvar fp = 0; fp < FRAME_PHI; fp++) begin : g_strip_p
            logic [SUM_W-1:0] acc_d;
            always_comb begin
                acc_d = '0;
                for (int k = -HALF; k <= HALF; k++) begin
                    if ((ENV - 1 + xe + k) >= 0 && (ENV - 1 + xe + k) < FRAME_ETA) begin
                        acc_d = acc_d + SUM_W'(towers_i[(fp*FRAME_ETA + ENV - 1 + xe + k)*TOWER_W +: TOWER_W]);
                    end
                end
            end
            assign strip_flat[(xe*FRAME_PHI + fp)*SUM_W +: SUM_W] = acc_d;
        end
    end

    // Phi accumulation of the strips gives the square window.
    for (genvar xp = 0; xp < XP; xp++) begin : g_win_p
        for (genvar xe = 0; xe < XE; xe++) begin : g_win_e
            logic [SUM_W-1:0] acc_d;
            always_comb begin
                acc_d = '0;
                for (int k = -HALF; k <= HALF; k++) begin
                    if ((ENV - 1 + xp + k) >= 0 && (ENV - 1 + xp + k) < FRAME_PHI) begin
                        acc_d = acc_d + strip_flat[(xe*FRAME_PHI + ENV - 1 + xp + k)*SUM_W +: SUM_W];
                    end
                end
            end
            assign sums_o[(xp*XE + xe)*SUM_W +: SUM_W] = acc_d;
        end
    end

endmodule

// File: rtl/jf_peak_test.sv
module jf_peak_test #(
    parameter int SUM_W = 17
) (
    input  logic [SUM_W-1:0]   centre_i,
    // Neighbours in raster order (phi-major, then eta), centre skipped:
    // entries 0..3 precede the centre, entries 4..7 follow it.
    input  logic [8*SUM_W-1:0] nbr_i,
    output logic               peak_o
);
    always_comb begin
        peak_o = (centre_i != '0);
        for (int n = 0; n < 8; n++) begin
            if (n < 4) begin
                peak_o = peak_o && (centre_i >  nbr_i[n*SUM_W +: SUM_W]);
            end else begin
                peak_o = peak_o && (centre_i >= nbr_i[n*SUM_W +: SUM_W]);
            end
        end
    end

endmodule

// File: rtl/sliding_jet_finder.sv
module sliding_jet_finder #(
    parameter int CORE_ETA = 12,
    parameter int CORE_PHI = 8,
    parameter int ENV      = 4,
    parameter int WIN      = 9,
    parameter int TOWER_W  = 10
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              in_valid,
    input  logic [(CORE_ETA+2*ENV)*(CORE_PHI+2*ENV)*TOWER_W-1:0] towers_i,
    output logic                                              out_valid,
    output logic [CORE_ETA*CORE_PHI-1:0]                      cand_flag,
    output logic [CORE_ETA*CORE_PHI*jf_pkg::OUT_W-1:0]        cand_sum
);
    localparam int FRAME_ETA = CORE_ETA + 2*ENV;
    localparam int FRAME_PHI = CORE_PHI + 2*ENV;
    localparam int HALF      = WIN / 2;
    localparam int NCORE     = CORE_ETA * CORE_PHI;
    localparam int XE        = CORE_ETA + 2;
    localparam int XP        = CORE_PHI + 2;
    localparam int NEXT      = XE * XP;
    localparam int SUM_W     = TOWER_W + $clog2(WIN*WIN);
    localparam int OUT_W     = jf_pkg::OUT_W;

    typedef struct packed {
        logic                     v1;
        logic [NEXT*SUM_W-1:0]    sums;
        logic                     v2;
        logic [NCORE-1:0]         flags;
        logic [NCORE*OUT_W-1:0]   outs;
    } state_t;

    state_t st_d, st_q;

    logic [NEXT*SUM_W-1:0]  win_sums;
    logic [NCORE-1:0]       peak;
    logic [NCORE*OUT_W-1:0] sat_sums;

    jf_window_sums #(
        .FRAME_ETA (FRAME_ETA),
        .FRAME_PHI (FRAME_PHI),
        .CORE_ETA  (CORE_ETA),
        .CORE_PHI  (CORE_PHI),
        .ENV       (ENV),
        .HALF      (HALF),
        .TOWER_W   (TOWER_W),
        .SUM_W     (SUM_W)
    ) u_sums (
        .towers_i (towers_i),
        .sums_o   (win_sums)
    );

    // Peak test for every core position, fed from the first register stage.
    for (genvar cp = 0; cp < CORE_PHI; cp++) begin : g_core_p
        for (genvar ce = 0; ce < CORE_ETA; ce++) begin : g_core_e
            localparam int CI = cp*CORE_ETA + ce;
            localparam int XI = (cp+1)*XE + (ce+1);
            logic [8*SUM_W-1:0] nbr;
            assign nbr[0*SUM_W +: SUM_W] = st_q.sums[(XI - XE - 1)*SUM_W +: SUM_W];
            assign nbr[1*SUM_W +: SUM_W] = st_q.sums[(XI - XE    )*SUM_W +: SUM_W];
            assign nbr[2*SUM_W +: SUM_W] = st_q.sums[(XI - XE + 1)*SUM_W +: SUM_W];
            assign nbr[3*SUM_W +: SUM_W] = st_q.sums[(XI - 1     )*SUM_W +: SUM_W];
            assign nbr[4*SUM_W +: SUM_W] = st_q.sums[(XI + 1     )*SUM_W +: SUM_W];
            assign nbr[5*SUM_W +: SUM_W] = st_q.sums[(XI + XE - 1)*SUM_W +: SUM_W];
            assign nbr[6*SUM_W +: SUM_W] = st_q.sums[(XI + XE    )*SUM_W +: SUM_W];
            assign nbr[7*SUM_W +: SUM_W] = st_q.sums[(XI + XE + 1)*SUM_W +: SUM_W];

            jf_peak_test #(.SUM_W(SUM_W)) u_peak (
                .centre_i (st_q.sums[XI*SUM_W +: SUM_W]),
                .nbr_i    (nbr),
                .peak_o   (peak[CI])
            );

            assign sat_sums[CI*OUT_W +: OUT_W] =
                jf_pkg::sat_to_out(32'(st_q.sums[XI*SUM_W +: SUM_W]));

            // R6: a flagged position never reports zero energy
            AST_ZERO_NEVER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
                cand_flag[CI] |-> (cand_sum[CI*OUT_W +: OUT_W] != '0)); // R6

            if (ce < CORE_ETA-1) begin : g_adj_e
                AST_NO_ETA_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
                    !(cand_flag[CI] && cand_flag[CI+1])); // R4
            end
            if (cp < CORE_PHI-1) begin : g_adj_p
                AST_NO_PHI_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
                    !(cand_flag[CI] && cand_flag[CI+CORE_ETA])); // R4
            end
        end
    end

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
        if (in_valid) begin
            st_d.sums = win_sums;
        end
        st_d.v2    = st_q.v1;
        st_d.flags = st_q.v1 ? peak : '0;
        if (st_q.v1) begin
            st_d.outs = sat_sums;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.v2;
    assign cand_flag = st_q.flags;
    assign cand_sum  = st_q.outs;

    AST_FRAME_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid); // R2
    AST_IDLE_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (cand_flag == '0)); // R8
    AST_IDLE_SUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> (!out_valid |-> $stable(cand_sum))); // R8

endmodule

// File: tb/sliding_jet_finder_tb.sv
module sliding_jet_finder_tb;

    localparam int CORE_ETA  = 12;
    localparam int CORE_PHI  = 8;
    localparam int ENV       = 4;
    localparam int WIN       = 9;
    localparam int TOWER_W   = 10;
    localparam int FRAME_ETA = CORE_ETA + 2*ENV;
    localparam int FRAME_PHI = CORE_PHI + 2*ENV;
    localparam int HALF      = WIN / 2;
    localparam int NCORE     = CORE_ETA * CORE_PHI;

    typedef struct packed {
        int fill;
        int e1; int p1; int v1;
        int e2; int p2; int v2;
    } vec_t;

    // Frame coordinates; e = -1 means no override.
    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{0,    -1, 0, 0,     -1, 0, 0},    // empty frame
        '{0,    10, 8, 100,   -1, 0, 0},    // isolated tower in core
        '{0,     8, 7, 50,    13, 10, 80},  // two unequal towers
        '{0,     7, 6, 60,    11, 6, 60},   // equal twins
        '{5,    -1, 0, 0,     -1, 0, 0},    // uniform field
        '{0,     1, 9, 900,    5, 9, 100},  // environment deposit near core edge
        '{1023, -1, 0, 0,     -1, 0, 0},    // full scale
        '{0,    19, 15, 700,  15, 11, 10}   // frame corner deposit
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [FRAME_ETA*FRAME_PHI*TOWER_W-1:0] towers = '0;
    logic out_valid;
    logic [NCORE-1:0] cand_flag;
    logic [NCORE*16-1:0] cand_sum;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int tw [FRAME_ETA][FRAME_PHI];
    int exp_sum [NCORE];
    bit exp_flag [NCORE];
    int save_sum [NCORE];
    bit save_flag [NCORE];

    always #5 clk = ~clk;

    sliding_jet_finder #(
        .CORE_ETA (CORE_ETA),
        .CORE_PHI (CORE_PHI),
        .ENV      (ENV),
        .WIN      (WIN),
        .TOWER_W  (TOWER_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .towers_i  (towers),
        .out_valid (out_valid),
        .cand_flag (cand_flag),
        .cand_sum  (cand_sum)
    );

    function automatic int wsum(int ce, int cp);
        int s = 0;
        for (int de = -HALF; de <= HALF; de++) begin
            for (int dp = -HALF; dp <= HALF; dp++) begin
                if (ce+de >= 0 && ce+de < FRAME_ETA && cp+dp >= 0 && cp+dp < FRAME_PHI)
                    s += tw[ce+de][cp+dp];
            end
        end
        return s;
    endfunction

    function automatic bit peak_model(int ce, int cp);
        int c = wsum(ce, cp);
        if (c == 0) return 0;
        for (int dp = -1; dp <= 1; dp++) begin
            for (int de = -1; de <= 1; de++) begin
                if (de != 0 || dp != 0) begin
                    int n = wsum(ce+de, cp+dp);
                    bit earlier = (dp < 0) || (dp == 0 && de < 0);
                    if (earlier ? !(c > n) : !(c >= n)) return 0;
                end
            end
        end
        return 1;
    endfunction

    task automatic load_vec(vec_t v);
        for (int fe = 0; fe < FRAME_ETA; fe++)
            for (int fp = 0; fp < FRAME_PHI; fp++)
                tw[fe][fp] = v.fill;
        if (v.e1 >= 0) tw[v.e1][v.p1] = v.v1;
        if (v.e2 >= 0) tw[v.e2][v.p2] = v.v2;
        for (int i = 0; i < NCORE; i++) begin
            int ce = i % CORE_ETA + ENV;
            int cp = i / CORE_ETA + ENV;
            int s  = wsum(ce, cp);
            exp_sum[i]  = (s > 65535) ? 65535 : s;
            exp_flag[i] = peak_model(ce, cp);
        end
    endtask

    task automatic pack_towers();
        for (int fe = 0; fe < FRAME_ETA; fe++)
            for (int fp = 0; fp < FRAME_PHI; fp++)
                towers[(fp*FRAME_ETA+fe)*TOWER_W +: TOWER_W] = TOWER_W'(tw[fe][fp]);
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic compare_all(string tag);
        int bad_s = -1;
        int bad_f = -1;
        for (int i = NCORE-1; i >= 0; i--) begin
            if (int'(cand_sum[i*16 +: 16]) != exp_sum[i]) bad_s = i;
            if (cand_flag[i] != exp_flag[i]) bad_f = i;
        end
        // R3 / R7: window sums
        check(bad_s < 0, "R3", {tag, " sum"},
              bad_s < 0 ? 0 : int'(cand_sum[bad_s*16 +: 16]), bad_s < 0 ? 0 : exp_sum[bad_s]);
        // R4 / R5 / R6: candidate flags
        check(bad_f < 0, "R4", {tag, " flag"},
              bad_f < 0 ? 0 : int'(cand_flag[bad_f]), bad_f < 0 ? 0 : int'(exp_flag[bad_f]));
    endtask

    task automatic run_frame();
        @(negedge clk);
        pack_towers();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(cand_flag == '0, "R1", "flags in reset", int'(cand_flag != '0), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R2: latency of exactly two register stages
        load_vec(VECS[1]);
        @(negedge clk);
        pack_towers();
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R2", "out_valid after capture edge", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check(out_valid == 1'b1, "R2", "out_valid after second edge", int'(out_valid), 1);
        compare_all("latency frame");
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R2", "out_valid one cycle wide", int'(out_valid), 0);

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            load_vec(VECS[k]);
            run_frame();
            check(out_valid == 1'b1, "R2", $sformatf("vector %0d valid", k), int'(out_valid), 1);
            compare_all($sformatf("vector %0d", k));
            if (k == 0)
                check(cand_flag == '0, "R6", "empty frame flags", int'(cand_flag != '0), 0);
            if (k == 4)
                check(cand_flag == NCORE'(1), "R4", "uniform field keeps raster-first only",
                      int'(cand_flag[0]) + 2*int'(cand_flag[NCORE-1:1] != '0), 1);
            if (k == 5)
                check(cand_flag[4*CORE_ETA] == 1'b0, "R5", "environment deposit suppresses edge",
                      int'(cand_flag[4*CORE_ETA]), 0);
            if (k == 6)
                check(cand_sum[15:0] == 16'hFFFF, "R7", "saturated sum",
                      int'(cand_sum[15:0]), 65535);
        end

        // R2: back-to-back frames keep order
        load_vec(VECS[2]);
        for (int i = 0; i < NCORE; i++) begin
            save_sum[i]  = exp_sum[i];
            save_flag[i] = exp_flag[i];
        end
        @(negedge clk);
        pack_towers();
        in_valid = 1'b1;
        load_vec(VECS[7]);
        @(negedge clk);
        pack_towers();
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < NCORE; i++) begin
            exp_sum[i]  = save_sum[i];
            exp_flag[i] = save_flag[i];
        end
        check(out_valid == 1'b1, "R2", "first of back-to-back valid", int'(out_valid), 1);
        compare_all("R2 first of pair");
        load_vec(VECS[7]);
        @(posedge clk);
        #1;
        check(out_valid == 1'b1, "R2", "second of back-to-back valid", int'(out_valid), 1);
        compare_all("R2 second of pair");

        // R8: idle cycles ignore the tower bus
        @(negedge clk);
        load_vec(VECS[6]);
        pack_towers();
        load_vec(VECS[7]);
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R8", "idle out_valid", int'(out_valid), 0);
        check(cand_flag == '0, "R8", "idle flags clear", int'(cand_flag != '0), 0);
        begin
            int bad = -1;
            for (int i = NCORE-1; i >= 0; i--)
                if (int'(cand_sum[i*16 +: 16]) != exp_sum[i]) bad = i;
            check(bad < 0, "R8", "idle sums held",
                  bad < 0 ? 0 : int'(cand_sum[bad*16 +: 16]), bad < 0 ? 0 : exp_sum[bad]);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule